// File: doc/BRIEF.md
# SDRAM Bank Read Timing Guard

This block sits between a read requester and a four-bank double-data-rate SDRAM command bus. It decides, cycle by cycle, whether the command offered this cycle may go out. The command can be a bank activate, a read, a read that closes its row automatically, or a precharge. A command that would break a bank's timing rule is stalled and can be offered again later. Each bank keeps its own state and its own down-counter, so reads to different banks can be placed back to back. While one bank closes its row, another bank can keep the read-data window busy.

For every granted read the block also produces a read-data-valid window. The window opens a fixed CAS latency after the read and stays open for half a burst length of clock cycles, because data moves on both clock edges. In each cycle of the window the block reports the bank and the two column addresses carried by that cycle: one on the rising edge and one on the falling edge. The columns follow the configured burst order.

Top module: `sdram_rd_guard`

## Requirements
- R1: After reset all four banks are idle, `rdValid` and `cmdError` are low, and a READ to any bank is not granted.
- R2: An ACTIVATE (op 0) to an idle bank is granted. A READ (op 1) to that bank is refused until exactly T_RCD cycles after the ACTIVATE's grant cycle, and is granted in that cycle.
- R3: For a READ granted in cycle t, `rdValid` is high in cycles t+CL through t+CL+BL/2-1, with `rdBank` equal to the read's bank, and low in cycle t+CL-1 and cycle t+CL+BL/2 when no other read is in flight.
- R4: The burst start column is {A9, A7..A0} of `cmdAddr`. In window cycle p, `rdColRise` carries burst beat 2p and `rdColFall` carries beat 2p+1. In sequential order, beat n is the start column with its low log2(BL) bits replaced by (start + n) mod BL; the upper bits are unchanged.
- R5: A READ with A8 high locks its bank. Every READ, PRECHARGE or ACTIVATE to that bank is refused until cycle t+BL/2+T_RP, where t is the READ's grant cycle. An ACTIVATE to that bank is granted in exactly that cycle.
- R6: A bank that is locked or precharging does not block other banks. A READ to another open bank issued BL/2 cycles after the locking read is granted, and the two windows join into one unbroken window of BL cycles.
- R7: Two READs, to any banks, are at least BL/2 cycles apart. A READ offered earlier is refused, and one offered exactly BL/2 cycles after the previous granted READ is granted.
- R8: A PRECHARGE (op 2) to an open bank is granted. An ACTIVATE to that bank is refused until T_RP cycles later and granted in that cycle. A PRECHARGE to an idle bank is granted and has no effect: an ACTIVATE to that bank in the next cycle is granted.
- R9: A READ to an idle or precharging bank is refused. An ACTIVATE to an open bank is refused. The reserved op 3 is never granted.
- R10: A refused command offered with `cmdForce` high raises `cmdError` for exactly the next cycle and is discarded: a forced READ produces no `rdValid`. A forced legal command is granted and raises no error.
- R11: `cmdGrant` and `cmdStall` respond in the same cycle as the offered command. `cmdStall` is `cmdValid` and not granted, and both are low when `cmdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is offered this cycle |
| cmdOp | input | 2 | 0 activate, 1 read, 2 precharge, 3 reserved |
| cmdBank | input | 2 | Target bank |
| cmdAddr | input | 10 | A8 is the auto-precharge flag on reads; {A9,A7..A0} is the start column |
| cmdForce | input | 1 | Requester insists on the command; a refusal is reported as an error |
| cmdGrant | output | 1 | Offered command is legal and taken this cycle |
| cmdStall | output | 1 | Offered command is refused this cycle |
| cmdError | output | 1 | A forced command was refused in the previous cycle |
| rdValid | output | 1 | Read data window cycle |
| rdBank | output | 2 | Bank whose data occupies this window cycle |
| rdColRise | output | 9 | Column of the rising-edge beat |
| rdColFall | output | 9 | Column of the falling-edge beat |

## Verification
The hardest case to reach is the auto-precharge lock. It has to be seen while another bank is streaming data. That proves the lock covers only its own bank and that the two windows join with no gap. The stimulus opens two banks and waits out tRCD. It then sends a read with auto-precharge to one bank and, exactly half a burst later, a plain read to the other. Next it probes the locked bank with a read, a precharge and a run of activates, one per cycle, to find the exact cycle the bank reopens.

// File: rtl/sdram_guard_pkg.sv
`timescale 1ns/1ps
package sdram_guard_pkg;

  localparam int BANKS  = 4;
  localparam int BANK_W = 2;
  localparam int ADDR_W = 10;
  localparam int COL_W  = 9;
  localparam int AP_BIT = 8;

  typedef enum logic [1:0] {
    OP_ACT  = 2'd0,
    OP_READ = 2'd1,
    OP_PRE  = 2'd2,
    OP_RSVD = 2'd3
  } cmdOpT;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APWAIT = 2'd2,
    BK_PRECH  = 2'd3
  } bankStateT;

  // strobes from control to the read-window datapath
  typedef struct packed {
    logic              rdIssue;
    logic [BANK_W-1:0] rdBank;
    logic [COL_W-1:0]  rdCol;
  } rdStrobeT;

endpackage

// File: rtl/sdram_guard_bank.sv
`timescale 1ns/1ps
module sdram_guard_bank
  import sdram_guard_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int HALF_BL = 4
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  hit,
  input  cmdOpT op,
  input  logic  autoPre,
  output logic  actOk,
  output logic  rdOk,
  output logic  preOk,
  output logic  isOpen
);

  localparam int TMAX0 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TMAX  = (TMAX0 > HALF_BL) ? TMAX0 : HALF_BL;
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [TW-1:0] RCD_LOAD = TW'(T_RCD - 1);
  localparam logic [TW-1:0] RP_LOAD  = TW'(T_RP - 1);
  localparam logic [TW-1:0] AP_LOAD  = TW'(HALF_BL - 1);

  bankStateT     stateQ, stateD;
  logic [TW-1:0] timerQ, timerD;
  logic          timerZero;

  assign timerZero = (timerQ == '0);

  always_comb begin
    actOk  = (stateQ == BK_IDLE) || ((stateQ == BK_PRECH) && timerZero);
    rdOk   = (stateQ == BK_OPEN) && timerZero;
    preOk  = (stateQ == BK_IDLE) || (stateQ == BK_OPEN);
    isOpen = (stateQ == BK_OPEN);
  end

  always_comb begin
    stateD = stateQ;
    timerD = timerZero ? timerQ : timerQ - 1'b1;
    if (hit) begin
      case (op)
        OP_ACT: begin
          stateD = BK_OPEN;
          timerD = RCD_LOAD;
        end
        OP_READ: begin
          if (autoPre) begin
            stateD = BK_APWAIT;
            timerD = AP_LOAD;
          end
        end
        OP_PRE: begin
          if (stateQ == BK_OPEN) begin
            stateD = BK_PRECH;
            timerD = RP_LOAD;
          end
        end
        default: ;
      endcase
    end else begin
      case (stateQ)
        BK_APWAIT: begin
          if (timerZero) begin
            stateD = BK_PRECH;
            timerD = RP_LOAD;
          end
        end
        BK_PRECH: begin
          if (timerZero) stateD = BK_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= BK_IDLE;
      timerQ <= '0;
    end else begin
      stateQ <= stateD;
      timerQ <= timerD;
    end
  end

  AST_READ_NEEDS_RCD: assert property (@(posedge clk) disable iff (!rstN)
    (hit && op == OP_READ) |-> (stateQ == BK_OPEN && timerZero)); // R2

  AST_LOCKED_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == BK_APWAIT) |-> !hit); // R5

  AST_PRECH_ACT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == BK_PRECH && hit) |-> (op == OP_ACT && timerZero)); // R8

endmodule

// File: rtl/sdram_guard_ctrl.sv
`timescale 1ns/1ps
module sdram_guard_ctrl
  import sdram_guard_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int HALF_BL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdForce,
  output logic              cmdGrant,
  output logic              cmdStall,
  output logic              cmdError,
  output rdStrobeT          strb
);

  localparam int GW = $clog2(HALF_BL + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(HALF_BL - 1);

  cmdOpT             opSel;
  logic              autoPre;
  logic [BANKS-1:0]  actOkV, rdOkV, preOkV, isOpenV, hitV;
  logic              legal;
  logic [GW-1:0]     gapQ;
  logic              errQ;

  assign opSel   = cmdOpT'(cmdOp);
  assign autoPre = cmdAddr[AP_BIT];

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    assign hitV[b] = cmdGrant && (cmdBank == BANK_W'(b));
    sdram_guard_bank #(
      .T_RCD  (T_RCD),
      .T_RP   (T_RP),
      .HALF_BL(HALF_BL)
    ) uBank (
      .clk    (clk),
      .rstN   (rstN),
      .hit    (hitV[b]),
      .op     (opSel),
      .autoPre(autoPre),
      .actOk  (actOkV[b]),
      .rdOk   (rdOkV[b]),
      .preOk  (preOkV[b]),
      .isOpen (isOpenV[b])
    );
  end

  always_comb begin
    case (opSel)
      OP_ACT:  legal = actOkV[cmdBank];
      OP_READ: legal = rdOkV[cmdBank] && (gapQ == '0);
      OP_PRE:  legal = preOkV[cmdBank];
      default: legal = 1'b0;
    endcase
  end

  assign cmdGrant = cmdValid && legal;
  assign cmdStall = cmdValid && !legal;
  assign cmdError = errQ;

  always_comb begin
    strb.rdIssue = cmdGrant && (opSel == OP_READ);
    strb.rdBank  = cmdBank;
    strb.rdCol   = {cmdAddr[9], cmdAddr[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapQ <= '0;
      errQ <= 1'b0;
    end else begin
      if (strb.rdIssue)    gapQ <= GAP_LOAD;
      else if (gapQ != '0) gapQ <= gapQ - 1'b1;
      errQ <= cmdValid && cmdForce && !legal;
    end
  end

  AST_FORCE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdForce && !cmdGrant) |=> cmdError); // R10

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdGrant && opSel == OP_ACT) |=> isOpenV[$past(cmdBank)]); // R2

endmodule

// File: rtl/sdram_guard_dpath.sv
`timescale 1ns/1ps
module sdram_guard_dpath
  import sdram_guard_pkg::*;
#(
  parameter int CL        = 2,
  parameter int BL        = 8,
  parameter bit BURST_SEQ = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobeT          strb,
  output logic              rdValid,
  output logic [BANK_W-1:0] rdBank,
  output logic [COL_W-1:0]  rdColRise,
  output logic [COL_W-1:0]  rdColFall
);

  localparam int HALF_BL = BL / 2;
  localparam int LB      = $clog2(BL);
  localparam logic [LB-1:0] REM_LOAD = LB'(HALF_BL - 1);

  logic [CL-1:0]     issuePipe;
  logic [COL_W-1:0]  colPipe  [CL];
  logic [BANK_W-1:0] bankPipe [CL];

  logic              head;
  logic [COL_W-1:0]  startQ, curStart;
  logic [BANK_W-1:0] bankQ;
  logic [LB-1:0]     pairQ, remQ, curPair;
  logic [LB-1:0]     beatRise, beatFall, lowRise, lowFall;

  assign head = issuePipe[CL-1];

  // CAS-latency delay line for issue, column and bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      issuePipe <= '0;
      for (int i = 0; i < CL; i++) begin
        colPipe[i]  <= '0;
        bankPipe[i] <= '0;
      end
    end else begin
      issuePipe[0] <= strb.rdIssue;
      colPipe[0]   <= strb.rdCol;
      bankPipe[0]  <= strb.rdBank;
      for (int i = 1; i < CL; i++) begin
        issuePipe[i] <= issuePipe[i-1];
        colPipe[i]   <= colPipe[i-1];
        bankPipe[i]  <= bankPipe[i-1];
      end
    end
  end

  // window occupancy and beat-pair position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      bankQ  <= '0;
      pairQ  <= '0;
      remQ   <= '0;
    end else if (head) begin
      startQ <= colPipe[CL-1];
      bankQ  <= bankPipe[CL-1];
      pairQ  <= LB'(1);
      remQ   <= REM_LOAD;
    end else if (remQ != '0) begin
      remQ  <= remQ - 1'b1;
      pairQ <= pairQ + 1'b1;
    end
  end

  assign rdValid  = head || (remQ != '0);
  assign rdBank   = head ? bankPipe[CL-1] : bankQ;
  assign curStart = head ? colPipe[CL-1] : startQ;
  assign curPair  = head ? '0 : pairQ;
  assign beatRise = curPair + curPair;
  assign beatFall = beatRise + 1'b1;

  if (BURST_SEQ) begin : gSeq
    assign lowRise = curStart[LB-1:0] + beatRise;
    assign lowFall = curStart[LB-1:0] + beatFall;
  end else begin : gIlv
    assign lowRise = curStart[LB-1:0] ^ beatRise;
    assign lowFall = curStart[LB-1:0] ^ beatFall;
  end

  assign rdColRise = {curStart[COL_W-1:LB], lowRise};
  assign rdColFall = {curStart[COL_W-1:LB], lowFall};

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (HALF_BL > 1 && strb.rdIssue) |=> !strb.rdIssue); // R7

  AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (int'(curPair) < HALF_BL)); // R4

endmodule

// File: rtl/sdram_rd_guard.sv
`timescale 1ns/1ps
module sdram_rd_guard
  import sdram_guard_pkg::*;
#(
  parameter int CL        = 2,
  parameter int BL        = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter bit BURST_SEQ = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [1:0]  cmdBank,
  input  logic [9:0]  cmdAddr,
  input  logic        cmdForce,
  output logic        cmdGrant,
  output logic        cmdStall,
  output logic        cmdError,
  output logic        rdValid,
  output logic [1:0]  rdBank,
  output logic [8:0]  rdColRise,
  output logic [8:0]  rdColFall
);

  localparam int HALF_BL = BL / 2;

  rdStrobeT strb;

  sdram_guard_ctrl #(
    .T_RCD  (T_RCD),
    .T_RP   (T_RP),
    .HALF_BL(HALF_BL)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdBank (cmdBank),
    .cmdAddr (cmdAddr),
    .cmdForce(cmdForce),
    .cmdGrant(cmdGrant),
    .cmdStall(cmdStall),
    .cmdError(cmdError),
    .strb    (strb)
  );

  sdram_guard_dpath #(
    .CL       (CL),
    .BL       (BL),
    .BURST_SEQ(BURST_SEQ)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdValid  (rdValid),
    .rdBank   (rdBank),
    .rdColRise(rdColRise),
    .rdColFall(rdColFall)
  );

endmodule

// File: tb/tb_sdram_rd_guard.sv
`timescale 1ns/1ps
module tb_sdram_rd_guard;

  localparam int CL   = 2;
  localparam int BL   = 8;
  localparam int HB   = 4;
  localparam int TRCD = 3;
  localparam int TRP  = 3;
  localparam int HN   = 1024;

  localparam logic [1:0] ACT = 2'd0, RD = 2'd1, PRE = 2'd2, RSV = 2'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [1:0] cmdBank = 2'd0;
  logic [9:0] cmdAddr = '0;
  logic       cmdForce = 1'b0;
  logic       cmdGrant, cmdStall, cmdError, rdValid;
  logic [1:0] rdBank;
  logic [8:0] rdColRise, rdColFall;

  int nChk = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic lastStall;

  logic       hV [HN];
  logic       hE [HN];
  logic [1:0] hB [HN];
  logic [8:0] hR [HN];
  logic [8:0] hF [HN];

  sdram_rd_guard dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr), .cmdForce(cmdForce),
    .cmdGrant(cmdGrant), .cmdStall(cmdStall), .cmdError(cmdError),
    .rdValid(rdValid), .rdBank(rdBank), .rdColRise(rdColRise),
    .rdColFall(rdColFall)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #2;
    if (cyc < HN) begin
      hV[cyc] = rdValid;
      hE[cyc] = cmdError;
      hB[cyc] = rdBank;
      hR[cyc] = rdColRise;
      hF[cyc] = rdColFall;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expCol(input logic [8:0] s, input int beat);
    return {s[8:3], 3'(int'(s[2:0]) + beat)};
  endfunction

  task automatic send(input logic [1:0] op, input logic [1:0] bank, input logic [8:0] col,
                      input logic ap, input logic frc, output logic g, output int at);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdBank  = bank;
    cmdAddr  = {col[8], ap, col[7:0]};
    cmdForce = frc;
    #1;
    g = cmdGrant;
    lastStall = cmdStall;
    at = cyc;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
    cmdForce = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkWin(input int c, input logic [1:0] bank, input logic [8:0] col);
    for (int k = 0; k < HB; k++) begin
      chk("R3 rdValid in window", hV[c+CL+k], 1'b1);
      chk("R3 rdBank in window", hB[c+CL+k], bank);
      chk("R4 rising column", hR[c+CL+k], expCol(col, 2*k));
      chk("R4 falling column", hF[c+CL+k], expCol(col, 2*k+1));
    end
  endtask

  task automatic testReset();
    logic g; int at;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    chk("R1 rdValid after reset", rdValid, 1'b0);
    chk("R1 cmdError after reset", cmdError, 1'b0);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = RD; cmdBank = 2'd0;
    #1;
    chk("R11 no grant without valid", cmdGrant, 1'b0);
    chk("R11 no stall without valid", cmdStall, 1'b0);
    send(RD, 2'd0, 9'h000, 1'b0, 1'b0, g, at);
    chk("R1 READ to idle bank refused", g, 1'b0);
    chk("R11 stall same cycle", lastStall, 1'b1);
  endtask

  task automatic testRcdWindow();
    logic g; int c, at;
    send(ACT, 2'd0, 9'h000, 1'b0, 1'b0, g, c);
    chk("R2 ACT to idle bank", g, 1'b1);
    for (int k = 1; k <= TRCD; k++) begin
      send(RD, 2'd0, 9'h1FD, 1'b0, 1'b0, g, at);
      chk("R2 READ against tRCD", g, (k == TRCD));
    end
    chk("R2 READ grant cycle", at - c, TRCD);
    waitCycles(10);
    chk("R3 window closed before", hV[at+CL-1], 1'b0);
    checkWin(at, 2'd0, 9'h1FD);
    chk("R3 window closed after", hV[at+CL+HB], 1'b0);
  endtask

  task automatic testGap();
    logic g; int c, at;
    send(RD, 2'd0, 9'h010, 1'b0, 1'b0, g, c);
    chk("R7 first READ", g, 1'b1);
    for (int k = 1; k <= HB; k++) begin
      send(RD, 2'd0, 9'h022, 1'b0, 1'b0, g, at);
      chk("R7 READ spacing", g, (k == HB));
    end
    chk("R7 second READ cycle", at - c, HB);
    waitCycles(12);
    checkWin(c, 2'd0, 9'h010);
    checkWin(at, 2'd0, 9'h022);
    chk("R7 joined window end", hV[c+CL+BL], 1'b0);
  endtask

  task automatic testApLock();
    logic g; int c, at;
    send(RD, 2'd0, 9'h040, 1'b1, 1'b0, g, c);
    chk("R5 READ with auto-precharge", g, 1'b1);
    send(RD, 2'd0, 9'h040, 1'b0, 1'b0, g, at);
    chk("R5 READ during lock", g, 1'b0);
    send(PRE, 2'd0, 9'h000, 1'b0, 1'b0, g, at);
    chk("R5 PRE during lock", g, 1'b0);
    g = 1'b0;
    for (int k = 0; k < 10 && !g; k++) begin
      send(ACT, 2'd0, 9'h000, 1'b0, 1'b0, g, at);
      if (!g) chk("R5 ACT before BL/2+tRP", (at - c) < (HB + TRP), 1'b1);
    end
    chk("R5 ACT granted", g, 1'b1);
    chk("R5 ACT grant cycle", at - c, HB + TRP);
    waitCycles(4);
    checkWin(c, 2'd0, 9'h040);
  endtask

  task automatic testInterleave();
    logic g; int c, a, b;
    send(ACT, 2'd1, 9'h000, 1'b0, 1'b0, g, c);
    chk("R6 ACT bank1", g, 1'b1);
    send(ACT, 2'd2, 9'h000, 1'b0, 1'b0, g, c);
    chk("R6 ACT bank2", g, 1'b1);
    waitCycles(TRCD);
    send(RD, 2'd1, 9'h0A3, 1'b1, 1'b0, g, a);
    chk("R6 READA bank1", g, 1'b1);
    waitCycles(HB - 1);
    send(RD, 2'd2, 9'h155, 1'b0, 1'b0, g, b);
    chk("R6 READ other bank during lock", g, 1'b1);
    chk("R6 READ interleave cycle", b - a, HB);
    waitCycles(12);
    checkWin(a, 2'd1, 9'h0A3);
    checkWin(b, 2'd2, 9'h155);
    chk("R6 joined window end", hV[a+CL+BL], 1'b0);
  endtask

  task automatic testPrecharge();
    logic g; int p, at;
    send(PRE, 2'd2, 9'h000, 1'b0, 1'b0, g, p);
    chk("R8 PRE to open bank", g, 1'b1);
    g = 1'b0;
    for (int k = 0; k < 8 && !g; k++) begin
      send(ACT, 2'd2, 9'h000, 1'b0, 1'b0, g, at);
      if (!g) chk("R8 ACT before tRP", (at - p) < TRP, 1'b1);
    end
    chk("R8 ACT after tRP granted", g, 1'b1);
    chk("R8 ACT grant cycle", at - p, TRP);
    send(PRE, 2'd3, 9'h000, 1'b0, 1'b0, g, at);
    chk("R8 PRE to idle bank", g, 1'b1);
    send(ACT, 2'd3, 9'h000, 1'b0, 1'b0, g, at);
    chk("R8 ACT right after idle PRE", g, 1'b1);
  endtask

  task automatic testRefuse();
    logic g; int at;
    send(ACT, 2'd3, 9'h000, 1'b0, 1'b0, g, at);
    chk("R9 ACT to open bank", g, 1'b0);
    send(RSV, 2'd3, 9'h000, 1'b0, 1'b0, g, at);
    chk("R9 reserved op", g, 1'b0);
    waitCycles(TRCD);
    send(PRE, 2'd3, 9'h000, 1'b0, 1'b0, g, at);
    chk("R9 PRE bank3", g, 1'b1);
    send(RD, 2'd3, 9'h000, 1'b0, 1'b0, g, at);
    chk("R9 READ to precharging bank", g, 1'b0);
    send(RD, 2'd1, 9'h000, 1'b0, 1'b0, g, at);
    chk("R9 READ to idle bank", g, 1'b0);
  endtask

  task automatic testForce();
    logic g; int f, f2;
    waitCycles(6);
    send(RD, 2'd1, 9'h077, 1'b0, 1'b1, g, f);
    chk("R10 forced illegal READ refused", g, 1'b0);
    waitCycles(CL + HB + 2);
    chk("R10 error next cycle", hE[f+1], 1'b1);
    chk("R10 error one cycle only", hE[f+2], 1'b0);
    for (int k = 1; k <= CL + HB; k++)
      chk("R10 discarded READ gives no data", hV[f+k], 1'b0);
    send(ACT, 2'd1, 9'h000, 1'b0, 1'b1, g, f2);
    chk("R10 forced legal ACT granted", g, 1'b1);
    waitCycles(2);
    chk("R10 no error for legal force", hE[f2+1], 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
      $finish;
    end
  end

  initial begin
    testReset();
    testRcdWindow();
    testGap();
    testApLock();
    testInterleave();
    testPrecharge();
    testRefuse();
    testForce();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

endmodule